// File: doc/BRIEF.md
# Line and Ring Switch Controller

This block commands the four switch enables of a telephone line interface: a pair of line-break switches that carry loop current and voice while the line is idle or in a call, and a ring-return plus a ring-access switch that connect a ringing generator to the loop. One mode input chooses between the idle/talk path and the power-ringing path. A hold input freezes that choice: the mode value present on its rising edge is kept for as long as the hold input stays high.

Three conditions open every switch and take priority over the mode and hold inputs. These are an active-low shutdown pin, a thermal-fault flag and a battery-fault flag, the last meaning the battery supply has gone above -10 V or is missing. All three pass through a two-flop synchronizer before use. Whenever the commanded path changes, including recovery from all-off, every switch is opened for a programmable dead time before the new set closes. A two-bit status output reports the present state.

Top module: `lrs_switch_ctrl`

## Requirements
- R1: With hold low, mode low and no all-off condition, the block settles with both line-break enables high, both ring enables low and status 01.
- R2: With hold low, mode high and no all-off condition, the block settles with both line-break enables low, ring-return and ring-access high and status 10.
- R3: A low level on the shutdown pin opens all four switches with status 00, whatever the hold and mode inputs are. It takes effect on the third rising clock edge after the pin changes.
- R4: A high thermal-fault flag opens all four switches with status 00, with the same three-edge latency as R3.
- R5: A high battery-fault flag opens all four switches with status 00, with the same three-edge latency as R3.
- R6: On the rising edge of hold, the mode value is captured. While hold stays high, the selection follows only that captured value, and mode changes have no effect on the switches.
- R7: When hold falls, the selection at once becomes the current mode input.
- R8: A change of selected path first opens all switches with status 11 for DEAD_CYC cycles, starting on the edge after the change is seen, and then closes the new set. Line-break and ring enables are never high together.
- R9: When every all-off condition has cleared, the block passes through the DEAD_CYC dead time with status 11. It then closes the path that the hold logic selects.
- R10: The path closed at the end of a dead time is the selection present on that last edge, even if the selection changed during the dead time.
- R11: During and right after reset, all switch enables are low and status is 00.
- R12: With parameter USE_SHDN_PIN set to 0, the shutdown pin is ignored and treated as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Path select: 0 idle/talk, 1 ringing |
| latch_en_i | input | 1 | Hold: captures mode on its rising edge |
| shdn_ni | input | 1 | Shutdown, active low, forces all off |
| therm_flt_i | input | 1 | Thermal fault flag, forces all off |
| vbat_flt_i | input | 1 | Battery fault flag, forces all off |
| line_brk_o | output | 2 | Line-break switch enables |
| ring_ret_o | output | 1 | Ring-return switch enable |
| ring_acc_o | output | 1 | Ring-access switch enable |
| status_o | output | 2 | 00 all off, 01 idle/talk, 10 ringing, 11 dead time |

## Verification
The main function is exercised by plain mode toggles with hold low, which separate the two paths and measure the dead time. Hold is raised with mode at 1 and again with mode at 0 and mode is then flipped, which shows whether the captured value is kept and released correctly. Each all-off source is asserted on its own, and shutdown is also asserted alongside hold, which tests priority and the three-edge latency. A mode flip during a dead time tells whether the final path follows the late selection. A second instance with the shutdown pin disabled shows that the tie-off takes effect.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_TALK = 2'b01,
    ST_RING = 2'b10,
    ST_DEAD = 2'b11
  } lrs_state_e;
endpackage

// File: rtl/lrs_sync.sv
module lrs_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff1_q, ff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= RST_VAL;
      ff2_q <= RST_VAL;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end

  assign q_o = ff2_q;
endmodule

// File: rtl/lrs_mode_latch.sv
module lrs_mode_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic latch_en_i,
  output logic sel_o
);
  logic lat_q, held_q, rise;

  assign rise = latch_en_i && !lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      lat_q <= latch_en_i;
      if (rise) held_q <= mode_i;
    end
  end

  // capture cycle passes mode straight through
  always_comb begin
    if (!latch_en_i || rise) sel_o = mode_i;
    else                     sel_o = held_q;
  end

  // R6: held selection stays put while hold remains high
  assert_hold_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && latch_en_i) |=> (!latch_en_i || $stable(sel_o)));
endmodule

// File: rtl/lrs_seq.sv
module lrs_seq
  import lrs_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       force_off_i,
  input  logic       want_ring_i,
  output lrs_state_e state_o
);
  localparam int unsigned CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
  localparam logic [CW-1:0] CNT_LOAD = CW'(DEAD_CYC - 1);

  lrs_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (force_off_i) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_DEAD;
          cnt_d   = CNT_LOAD;
        end
        ST_TALK: if (want_ring_i) begin
          state_d = ST_DEAD;
          cnt_d   = CNT_LOAD;
        end
        ST_RING: if (!want_ring_i) begin
          state_d = ST_DEAD;
          cnt_d   = CNT_LOAD;
        end
        ST_DEAD: begin
          if (cnt_q == '0) state_d = want_ring_i ? ST_RING : ST_TALK;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  assert_off_forced_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> (state_q == ST_OFF));

  assert_talk_no_direct_ring_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TALK) |=> (state_q != ST_RING));

  assert_ring_no_direct_talk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RING) |=> (state_q != ST_TALK));

  assert_off_via_dead_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && !force_off_i) |=> (state_q == ST_DEAD));

  assert_dead_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEAD && cnt_q == '0 && !force_off_i)
      |=> (state_q == ($past(want_ring_i) ? ST_RING : ST_TALK)));
endmodule

// File: rtl/lrs_switch_ctrl.sv
module lrs_switch_ctrl
  import lrs_pkg::*;
#(
  parameter int unsigned DEAD_CYC     = 16,
  parameter bit          USE_SHDN_PIN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_i,
  input  logic       latch_en_i,
  input  logic       shdn_ni,
  input  logic       therm_flt_i,
  input  logic       vbat_flt_i,
  output logic [1:0] line_brk_o,
  output logic       ring_ret_o,
  output logic       ring_acc_o,
  output logic [1:0] status_o
);
  logic       shdn_n_eff;
  logic [2:0] flt_raw, flt_s;
  logic       force_off, want_ring;
  lrs_state_e state;

  generate
    if (USE_SHDN_PIN) begin : g_shdn_pin
      assign shdn_n_eff = shdn_ni;
    end else begin : g_shdn_tie
      assign shdn_n_eff = 1'b1;
    end
  endgenerate

  assign flt_raw = {vbat_flt_i, therm_flt_i, !shdn_n_eff};

  // reset value holds switches open until inputs are seen
  lrs_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (flt_raw),
    .q_o   (flt_s)
  );

  assign force_off = |flt_s;

  lrs_mode_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .latch_en_i(latch_en_i),
    .sel_o     (want_ring)
  );

  lrs_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .force_off_i(force_off),
    .want_ring_i(want_ring),
    .state_o    (state)
  );

  assign line_brk_o = (state == ST_TALK) ? 2'b11 : 2'b00;
  assign ring_ret_o = (state == ST_RING);
  assign ring_acc_o = (state == ST_RING);
  assign status_o   = state;

  assert_no_overlap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|line_brk_o) && (ring_ret_o || ring_acc_o)));

  assert_reset_open_R11: assert property (@(posedge clk_i)
    !rst_ni |-> (line_brk_o == 2'b00 && !ring_ret_o && !ring_acc_o));
endmodule

// File: tb/lrs_switch_ctrl_tb.sv
module lrs_switch_ctrl_tb;
  localparam int DEAD = 3;
  localparam logic [1:0] S_OFF = 2'b00, S_TALK = 2'b01, S_RING = 2'b10, S_DEAD = 2'b11;

  typedef struct {
    int         cyc;
    logic [1:0] st;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode = 1'b0, latch_en = 1'b0, shdn_n = 1'b1, therm = 1'b0, vbat = 1'b0;
  logic [1:0] line_brk, status, line_brk2, status2;
  logic ring_ret, ring_acc, ring_ret2, ring_acc2;

  int cyc = 0, base = 0, checks = 0, failures = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  lrs_switch_ctrl #(.DEAD_CYC(DEAD), .USE_SHDN_PIN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .latch_en_i(latch_en),
    .shdn_ni(shdn_n), .therm_flt_i(therm), .vbat_flt_i(vbat),
    .line_brk_o(line_brk), .ring_ret_o(ring_ret), .ring_acc_o(ring_acc),
    .status_o(status));

  lrs_switch_ctrl #(.DEAD_CYC(DEAD), .USE_SHDN_PIN(1'b0)) u_nopin (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .latch_en_i(latch_en),
    .shdn_ni(1'b0), .therm_flt_i(therm), .vbat_flt_i(vbat),
    .line_brk_o(line_brk2), .ring_ret_o(ring_ret2), .ring_acc_o(ring_acc2),
    .status_o(status2));

  function automatic logic [3:0] pins_of(input logic [1:0] st);
    return (st == S_TALK) ? 4'b1100 : (st == S_RING) ? 4'b0011 : 4'b0000;
  endfunction

  task automatic check_now(input logic [1:0] st, input string req);
    logic [3:0] got, exp;
    got = {line_brk, ring_ret, ring_acc};
    exp = pins_of(st);
    checks++;
    if (status !== st || got !== exp) begin
      failures++;
      $display("FAIL %s cyc=%0d status=%b pins=%b expected status=%b pins=%b",
               req, cyc, status, got, st, exp);
    end
  endtask

  task automatic drv(input logic m, input logic l, input logic s, input logic t, input logic v);
    @(negedge clk);
    mode = m; latch_en = l; shdn_n = s; therm = t; vbat = v;
    base = cyc;
  endtask

  task automatic expect_at(input int k, input logic [1:0] st, input string req);
    q.push_back('{cyc: base + k, st: st, req: req});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare queued expectations in their cycle
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t it;
        it = q.pop_front();
        if (it.cyc < cyc) begin
          checks++; failures++;
          $display("FAIL %s missed cycle %0d actual=%b expected=%b", it.req, it.cyc, status, it.st);
        end else check_now(it.st, it.req);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #7;
    check_now(S_OFF, "R11 in reset");
    drv(0, 0, 1, 0, 0);
    rst_ni = 1'b1;
    expect_at(1, S_OFF, "R11 after reset");
    expect_at(3, S_DEAD, "R9 recover dead start");
    expect_at(5, S_DEAD, "R9 recover dead end");
    expect_at(6, S_TALK, "R1 idle/talk");
    idle(8);
    checks++;
    if (status2 !== S_TALK) begin
      failures++;
      $display("FAIL R12 pin ignored actual=%b expected=%b", status2, S_TALK);
    end

    // R2 / R8 ringing and dead time
    drv(1, 0, 1, 0, 0);
    expect_at(1, S_DEAD, "R8 dead start");
    expect_at(3, S_DEAD, "R8 dead end");
    expect_at(4, S_RING, "R2 ringing");
    idle(6);
    drv(0, 0, 1, 0, 0);
    expect_at(1, S_DEAD, "R8 dead to talk");
    expect_at(4, S_TALK, "R1 back to talk");
    idle(6);

    // R6 capture 1, ignore mode, R7 release
    drv(1, 1, 1, 0, 0);
    expect_at(1, S_DEAD, "R6 capture edge");
    expect_at(4, S_RING, "R6 captured ring");
    idle(6);
    drv(0, 1, 1, 0, 0);
    expect_at(1, S_RING, "R6 mode ignored");
    expect_at(5, S_RING, "R6 mode ignored later");
    idle(6);
    drv(0, 0, 1, 0, 0);
    expect_at(1, S_DEAD, "R7 release");
    expect_at(4, S_TALK, "R7 follows mode");
    idle(6);

    // R6 capture 0
    drv(0, 1, 1, 0, 0);
    idle(2);
    drv(1, 1, 1, 0, 0);
    expect_at(1, S_TALK, "R6 hold talk");
    expect_at(6, S_TALK, "R6 hold talk later");
    idle(8);
    drv(1, 0, 1, 0, 0);
    expect_at(1, S_DEAD, "R7 release to ring");
    expect_at(4, S_RING, "R7 ring");
    idle(6);
    drv(0, 0, 1, 0, 0);
    expect_at(4, S_TALK, "R1 talk again");
    idle(6);

    // R3 shutdown priority, with hold capturing ring
    drv(0, 0, 0, 0, 0);
    expect_at(2, S_TALK, "R3 latency");
    expect_at(3, S_OFF, "R3 shutdown");
    idle(5);
    drv(1, 1, 0, 0, 0);
    expect_at(1, S_OFF, "R3 over hold/mode");
    expect_at(6, S_OFF, "R3 over hold/mode later");
    idle(7);
    drv(0, 1, 1, 0, 0);
    expect_at(2, S_OFF, "R9 still off");
    expect_at(3, S_DEAD, "R9 dead");
    expect_at(5, S_DEAD, "R9 dead end");
    expect_at(6, S_RING, "R9 resumes held ring");
    idle(8);
    drv(1, 0, 1, 0, 0);
    expect_at(3, S_RING, "R7 release same path");
    idle(4);

    // R4 thermal
    drv(1, 0, 1, 1, 0);
    expect_at(2, S_RING, "R4 latency");
    expect_at(3, S_OFF, "R4 thermal off");
    idle(6);
    drv(1, 0, 1, 0, 0);
    expect_at(3, S_DEAD, "R9 after thermal");
    expect_at(6, S_RING, "R9 ring after thermal");
    idle(8);

    // R5 battery
    drv(1, 0, 1, 0, 1);
    expect_at(3, S_OFF, "R5 battery off");
    idle(6);
    drv(0, 0, 1, 0, 0);
    expect_at(3, S_DEAD, "R9 after battery");
    expect_at(6, S_TALK, "R9 talk after battery");
    idle(8);

    // R10 selection changes during dead time
    drv(1, 0, 1, 0, 0);
    expect_at(1, S_DEAD, "R10 dead");
    drv(0, 0, 1, 0, 0);
    expect_at(3, S_TALK, "R10 final selection");
    idle(6);

    done = 1'b1;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d pending expected=0", q.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule